// File: doc/BRIEF.md
# DMA Peripheral Request Handshake Engine

This block sits on the peripheral side of a DMA request/acknowledge sideband. Its request channel is a valid/ready handshake that tells the DMA controller a data request is ready. A request is a single-beat request or a burst request, and it can carry a marker for the final request of a transfer. The same channel also returns an answer when the controller asks for a flush. Its acknowledge channel is a second valid/ready handshake. On that channel the controller reports that a single or burst transaction has finished, or asks for a flush.

The engine decides by itself when to request. It compares the local buffer occupancy against a burst threshold, and it keeps a down-counter of the beats that remain in the current transfer. At most one request is in flight at any time. A flush drops all pending work and produces exactly one flush answer. An acknowledge with the reserved code sets a sticky error flag. All signalling is synchronous to one clock, and the reset is synchronous and active low.

Top module: `dma_req_agent`

## Requirements
- R1: While `req_valid` is high and `req_ready` is low, on the next cycle `req_valid` stays high and `req_kind` and `req_final` keep their values.
- R2: `req_kind` encodes 2'b00 for a single request, 2'b01 for a burst request and 2'b10 for a flush answer. The value 2'b11 is never driven while `req_valid` is high.
- R3: `req_final` is high exactly when the request uses up all remaining beats of the transfer. It is always low when `req_kind` is 2'b10.
- R4: A burst request (2'b01) is issued when `burst_level` is non-zero, `occupancy >= burst_level` and the remaining beats are at least `burst_level`. The burst consumes `burst_level` beats.
- R5: In all other cases a single request (2'b00) consuming one beat is issued when `occupancy` is non-zero and beats remain. With zero occupancy or zero remaining beats, no request is raised.
- R6: After a request handshake, no further data request is raised until the matching completion is accepted: `ack_kind` 2'b00 for a single request, 2'b01 for a burst request. A completion of the other kind is accepted and ignored.
- R7: An accepted `ack_kind` of 2'b10 (flush) clears the remaining beats and the outstanding request. The block then raises exactly one request with `req_kind` 2'b10, and after its handshake it stays idle.
- R8: A flush accepted while a data request is waiting for `req_ready` leaves that request unchanged until its handshake. The flush answer follows right after that handshake.
- R9: `ack_ready` is high except from the acceptance of a flush until the handshake of its flush answer.
- R10: An accepted `ack_kind` of 2'b11 sets `proto_err`, which stays high until reset. The request state does not change.
- R11: With `rst_n` low at a clock edge, the next cycle shows `req_valid` low, `proto_err` low and `ack_ready` high.
- R12: A `xfer_load` pulse loads `xfer_len` beats only when the engine is idle with zero remaining beats. At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Request-channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| occupancy | input | OCC_W | Beats currently available in the local buffer |
| burst_level | input | OCC_W | Burst threshold and burst size in beats |
| xfer_load | input | 1 | Start a transfer of `xfer_len` beats |
| xfer_len | input | CNT_W | Beat count of the new transfer |
| req_valid | output | 1 | Request channel valid |
| req_ready | input | 1 | Request channel ready from controller |
| req_kind | output | 2 | Request type code |
| req_final | output | 1 | Final request of the transfer |
| ack_valid | input | 1 | Acknowledge channel valid from controller |
| ack_ready | output | 1 | Acknowledge channel ready |
| ack_kind | input | 2 | Acknowledge type code |
| proto_err | output | 1 | Sticky reserved-acknowledge flag |

## Verification
The checker tracks the outstanding request on its own, so its one-in-flight property assumes that the controller sends completions only through the acknowledge handshake. It does not assume the controller is well behaved: a mismatched or reserved acknowledge must not confuse the checker. The bench changes `occupancy` and `burst_level` only while no request is waiting. It pulses `xfer_load` only at chosen points. It drives `req_ready` and `ack_valid` at the falling edge, so each handshake completes at a known rising edge. The bench sends reserved and mismatched acknowledges on purpose, and it sends flushes both while a request is waiting and while a completion is awaited.

// File: rtl/dma_req_pkg.sv
// Shared encodings for the DMA peripheral request engine.
// Assumes 2-bit type codes on both sideband channels.
package dma_req_pkg;

    typedef enum logic [1:0] {
        RQ_SINGLE    = 2'b00,
        RQ_BURST     = 2'b01,
        RQ_FLUSH_ACK = 2'b10,
        RQ_RSVD      = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        AK_SINGLE_DONE = 2'b00,
        AK_BURST_DONE  = 2'b01,
        AK_FLUSH_REQ   = 2'b10,
        AK_RSVD        = 2'b11
    } ack_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_REQ   = 2'b01,
        ST_WAIT  = 2'b10,
        ST_FLUSH = 2'b11
    } eng_state_e;

endpackage

// File: rtl/dma_req_pick.sv
// Request selector: picks burst or single, the beats consumed and the final
// marker from buffer occupancy, burst threshold and remaining beats.
// Assumes a burst threshold of zero disables bursts. Purely combinational.
module dma_req_pick #(
    parameter int OCC_W = 4,
    parameter int CNT_W = 8
) (
    input  logic [OCC_W-1:0] occupancy,
    input  logic [OCC_W-1:0] burst_level,
    input  logic [CNT_W-1:0] remaining,
    output logic             pick_go,
    output logic             pick_burst,
    output logic [CNT_W-1:0] pick_beats,
    output logic             pick_last
);
    localparam int CW = (CNT_W > OCC_W) ? CNT_W : OCC_W;

    logic [CW-1:0] occ_x;
    logic [CW-1:0] lvl_x;
    logic [CW-1:0] rem_x;
    logic [CW-1:0] beats_x;
    logic          burst_ok;
    logic          single_ok;

    // Widen all operands to one common width before comparing.
    always_comb begin
        occ_x = CW'(occupancy);
        lvl_x = CW'(burst_level);
        rem_x = CW'(remaining);
    end

    // Choose burst when threshold met in both buffer and transfer, else single.
    always_comb begin
        burst_ok   = (lvl_x != '0) && (occ_x >= lvl_x) && (rem_x >= lvl_x);
        single_ok  = (occ_x != '0) && (rem_x != '0);
        pick_go    = burst_ok || single_ok;
        pick_burst = burst_ok;
        beats_x    = burst_ok ? lvl_x : CW'(1);
        pick_beats = CNT_W'(beats_x);
        pick_last  = (rem_x == beats_x);
    end

endmodule

// File: rtl/dma_beat_counter.sv
// Remaining-beat down-counter for the current transfer.
// Assumes the caller never decrements by more than what remains.
// Priority: clear, then load, then decrement.
module dma_beat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic [CNT_W-1:0] dec_val,
    output logic [CNT_W-1:0] remaining
);
    // Update the remaining count on flush, load or issued request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (clear) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec) begin
            remaining <= remaining - dec_val;
        end
    end

endmodule

// File: rtl/dma_ack_decode.sv
// Acknowledge-channel decoder: turns accepted acknowledges into one-cycle
// events and keeps a sticky flag for the reserved code.
// Assumes ack_ready comes from registered state only.
module dma_ack_decode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_valid,
    input  logic       ack_ready,
    input  logic [1:0] ack_kind,
    output logic       ev_single,
    output logic       ev_burst,
    output logic       ev_flush,
    output logic       proto_err
);
    import dma_req_pkg::*;

    logic      taken;
    ack_kind_e kind;
    logic      ev_rsvd;

    // Decode the accepted acknowledge into per-kind events.
    always_comb begin
        taken     = ack_valid && ack_ready;
        kind      = ack_kind_e'(ack_kind);
        ev_single = taken && (kind == AK_SINGLE_DONE);
        ev_burst  = taken && (kind == AK_BURST_DONE);
        ev_flush  = taken && (kind == AK_FLUSH_REQ);
        ev_rsvd   = taken && (kind == AK_RSVD);
    end

    // Hold the protocol error until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else if (ev_rsvd) begin
            proto_err <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_req_agent.sv
// Peripheral-side DMA request engine. Raises single or burst requests
// from buffer occupancy and remaining beats, keeps one request in flight,
// and answers controller flushes with one flush-answer request.
// Assumes occupancy and burst_level are steady while a request waits.
module dma_req_agent #(
    parameter int OCC_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occupancy,
    input  logic [OCC_W-1:0] burst_level,
    input  logic             xfer_load,
    input  logic [CNT_W-1:0] xfer_len,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [1:0]       req_kind,
    output logic             req_final,
    input  logic             ack_valid,
    output logic             ack_ready,
    input  logic [1:0]       ack_kind,
    output logic             proto_err
);
    import dma_req_pkg::*;

    eng_state_e       state_q;
    eng_state_e       state_d;
    req_kind_e        kind_q;
    logic             last_q;
    logic [CNT_W-1:0] beats_q;
    logic             flush_pend_q;

    logic [CNT_W-1:0] remaining;
    logic             pick_go;
    logic             pick_burst;
    logic [CNT_W-1:0] pick_beats;
    logic             pick_last;
    logic             ev_single;
    logic             ev_burst;
    logic             ev_flush;
    logic             hs;
    logic             done_match;
    logic             cnt_load;
    logic             cnt_dec;

    dma_req_pick #(
        .OCC_W(OCC_W),
        .CNT_W(CNT_W)
    ) i_pick (
        .occupancy  (occupancy),
        .burst_level(burst_level),
        .remaining  (remaining),
        .pick_go    (pick_go),
        .pick_burst (pick_burst),
        .pick_beats (pick_beats),
        .pick_last  (pick_last)
    );

    dma_ack_decode i_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_valid(ack_valid),
        .ack_ready(ack_ready),
        .ack_kind (ack_kind),
        .ev_single(ev_single),
        .ev_burst (ev_burst),
        .ev_flush (ev_flush),
        .proto_err(proto_err)
    );

    dma_beat_counter #(
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ev_flush),
        .load     (cnt_load),
        .load_val (xfer_len),
        .dec      (cnt_dec),
        .dec_val  (beats_q),
        .remaining(remaining)
    );

    // Drive the request and acknowledge channel outputs from state.
    always_comb begin
        req_valid = (state_q == ST_REQ) || (state_q == ST_FLUSH);
        req_kind  = (state_q == ST_FLUSH) ? RQ_FLUSH_ACK : kind_q;
        req_final = (state_q == ST_REQ) && last_q;
        ack_ready = (state_q != ST_FLUSH) && !flush_pend_q;
    end

    // Derive handshake, matching completion and counter controls.
    always_comb begin
        hs         = req_valid && req_ready;
        done_match = (ev_single && (kind_q == RQ_SINGLE)) ||
                     (ev_burst  && (kind_q == RQ_BURST));
        cnt_load   = xfer_load && (state_q == ST_IDLE) && (remaining == '0);
        cnt_dec    = (state_q == ST_REQ) && hs && !flush_pend_q && !ev_flush;
    end

    // Next-state selection for the request engine.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (ev_flush) begin
                    state_d = ST_FLUSH;
                end else if (pick_go) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (hs) begin
                    state_d = (flush_pend_q || ev_flush) ? ST_FLUSH : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ev_flush) begin
                    state_d = ST_FLUSH;
                end else if (done_match) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                if (hs) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the chosen request when leaving idle for a data request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= RQ_SINGLE;
            last_q  <= 1'b0;
            beats_q <= '0;
        end else if ((state_q == ST_IDLE) && (state_d == ST_REQ)) begin
            kind_q  <= pick_burst ? RQ_BURST : RQ_SINGLE;
            last_q  <= pick_last;
            beats_q <= pick_beats;
        end
    end

    // Remember a flush that arrived while a data request was waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_pend_q <= 1'b0;
        end else if (state_q != ST_REQ) begin
            flush_pend_q <= 1'b0;
        end else if (hs) begin
            flush_pend_q <= 1'b0;
        end else if (ev_flush) begin
            flush_pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_req_agent_chk.sv
// Protocol checker for dma_req_agent, attached with bind. Tracks the
// in-flight request from the port handshakes alone.
module dma_req_agent_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       req_final,
    input logic       ack_valid,
    input logic       ack_ready,
    input logic [1:0] ack_kind,
    input logic       proto_err
);
    logic out_q;
    logic okind_q;

    // Follow the in-flight data request from handshakes on both channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= 1'b0;
            okind_q <= 1'b0;
        end else if (ack_valid && ack_ready && (ack_kind == 2'b10)) begin
            out_q <= 1'b0;
        end else if (req_valid && req_ready && (req_kind != 2'b10)) begin
            out_q   <= 1'b1;
            okind_q <= req_kind[0];
        end else if (req_valid && req_ready) begin
            out_q <= 1'b0;
        end else if (out_q && ack_valid && ack_ready && (ack_kind == {1'b0, okind_q})) begin
            out_q <= 1'b0;
        end
    end

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_kind) && $stable(req_final)));

    assert_no_rsvd_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_kind != 2'b11));

    assert_flush_not_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 2'b10)) |-> !req_final);

    assert_one_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !(req_valid && (req_kind != 2'b10)));

    assert_single_flush_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_kind == 2'b10)) |=> !req_valid);

    assert_ready_low_in_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 2'b10)) |-> !ack_ready);

    assert_rsvd_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_ready && (ack_kind == 2'b11)) |=> proto_err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    assert_reset_state_R11: assert property (@(posedge clk)
        !rst_n |=> (!req_valid && !proto_err && ack_ready));

endmodule

bind dma_req_agent dma_req_agent_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_kind (req_kind),
    .req_final(req_final),
    .ack_valid(ack_valid),
    .ack_ready(ack_ready),
    .ack_kind (ack_kind),
    .proto_err(proto_err)
);

// File: tb/test_dma_req_agent.sv
module test_dma_req_agent;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] occupancy;
    logic [3:0] burst_level;
    logic       xfer_load;
    logic [7:0] xfer_len;
    logic       req_valid;
    logic       req_ready;
    logic [1:0] req_kind;
    logic       req_final;
    logic       ack_valid;
    logic       ack_ready;
    logic [1:0] ack_kind;
    logic       proto_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dma_req_agent #(.OCC_W(4), .CNT_W(8)) i_dma_req_agent (
        .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .burst_level(burst_level),
        .xfer_load(xfer_load), .xfer_len(xfer_len), .req_valid(req_valid),
        .req_ready(req_ready), .req_kind(req_kind), .req_final(req_final),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_kind(ack_kind),
        .proto_err(proto_err)
    );

    // Fields: occupancy, burst_level, length, expected kind, expected final.
    localparam logic [18:0] VEC [0:7] = '{
        {4'd4,  4'd4,  8'd10, 2'b01, 1'b0},
        {4'd4,  4'd4,  8'd4,  2'b01, 1'b1},
        {4'd3,  4'd4,  8'd10, 2'b00, 1'b0},
        {4'd8,  4'd4,  8'd3,  2'b00, 1'b0},
        {4'd1,  4'd4,  8'd1,  2'b00, 1'b1},
        {4'd5,  4'd0,  8'd6,  2'b00, 1'b0},
        {4'd15, 4'd15, 8'd15, 2'b01, 1'b1},
        {4'd2,  4'd1,  8'd2,  2'b01, 1'b0}
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<=100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; occupancy = '0; burst_level = '0; xfer_load = 1'b0;
        xfer_len = '0; req_ready = 1'b0; ack_valid = 1'b0; ack_kind = 2'b00;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic load(input logic [7:0] len);
        xfer_load = 1'b1; xfer_len = len;
        step();
        xfer_load = 1'b0;
    endtask

    task automatic wait_req(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (req_valid) begin
                seen = 1'b1;
                break;
            end
            step();
        end
        chk(req, int'(seen), 1);
    endtask

    task automatic handshake();
        req_ready = 1'b1;
        step();
        req_ready = 1'b0;
    endtask

    task automatic send_ack(input logic [1:0] k);
        ack_valid = 1'b1; ack_kind = k;
        step();
        ack_valid = 1'b0;
    endtask

    task automatic quiet(input string req, input int n);
        bit any = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            if (req_valid) any = 1'b1;
        end
        chk(req, int'(any), 0);
    endtask

    initial begin
        step();
        do_reset();
        // R11: reset values at the ports
        chk("R11 req_valid", int'(req_valid), 0);
        chk("R11 ack_ready", int'(ack_ready), 1);
        chk("R11 proto_err", int'(proto_err), 0);

        // Vector walk: R4 burst choice, R5 single choice, R3 final marker
        for (int v = 0; v < 8; v++) begin
            do_reset();
            occupancy   = VEC[v][18:15];
            burst_level = VEC[v][14:11];
            load(VEC[v][10:3]);
            wait_req("R5 request raised");
            chk($sformatf("R4 R5 kind vec%0d", v), int'(req_kind), int'(VEC[v][2:1]));
            chk($sformatf("R3 final vec%0d", v), int'(req_final), int'(VEC[v][0]));
            handshake();
            send_ack(VEC[v][2:1]);
        end

        // Countdown across several requests: R4, R5, R3
        do_reset();
        occupancy = 4'd4; burst_level = 4'd4;
        load(8'd6);
        wait_req("R4 first");
        chk("R4 burst kind", int'(req_kind), 1);
        chk("R3 not final", int'(req_final), 0);
        handshake(); send_ack(2'b01);
        wait_req("R5 second");
        chk("R5 single after short remainder", int'(req_kind), 0);
        chk("R3 not final 2", int'(req_final), 0);
        handshake(); send_ack(2'b00);
        wait_req("R5 third");
        chk("R3 final on last beat", int'(req_final), 1);
        handshake(); send_ack(2'b00);
        quiet("R5 no request when no beats remain", 5);

        // Zero occupancy: R5
        do_reset();
        burst_level = 4'd4;
        load(8'd4);
        quiet("R5 no request with empty buffer", 6);
        occupancy = 4'd2;
        wait_req("R5 request once data arrives");
        chk("R5 single kind", int'(req_kind), 0);
        handshake(); send_ack(2'b00);

        // Hold, mismatched completion, reserved code, late load: R1 R6 R10 R12
        do_reset();
        occupancy = 4'd1; burst_level = 4'd4;
        load(8'd3);
        wait_req("R1 first request");
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R1 valid held", int'(req_valid), 1);
            chk("R1 kind held", int'(req_kind), 0);
        end
        handshake(); send_ack(2'b00);
        wait_req("R6 second request");
        handshake();
        chk("R9 ready while waiting", int'(ack_ready), 1);
        send_ack(2'b01);
        quiet("R6 mismatched completion ignored", 4);
        send_ack(2'b11);
        chk("R10 error set", int'(proto_err), 1);
        quiet("R10 state unchanged after reserved code", 3);
        load(8'd5);
        send_ack(2'b00);
        wait_req("R6 next request after match");
        chk("R3 final third", int'(req_final), 1);
        handshake(); send_ack(2'b00);
        quiet("R12 load during transfer ignored", 5);
        chk("R10 error sticky", int'(proto_err), 1);

        // Flush while awaiting completion: R7 R9 R3
        do_reset();
        occupancy = 4'd1; burst_level = 4'd4;
        load(8'd5);
        wait_req("R7 request");
        handshake();
        send_ack(2'b10);
        chk("R7 flush answer valid", int'(req_valid), 1);
        chk("R7 flush answer kind", int'(req_kind), 2);
        chk("R3 flush answer not final", int'(req_final), 0);
        chk("R9 ready low during flush", int'(ack_ready), 0);
        handshake();
        chk("R7 single flush answer", int'(req_valid), 0);
        chk("R9 ready back high", int'(ack_ready), 1);
        quiet("R7 beats cleared by flush", 6);

        // Flush while a request waits for ready: R8 R9
        do_reset();
        occupancy = 4'd1; burst_level = 4'd4;
        load(8'd5);
        wait_req("R8 request");
        chk("R9 ready before flush", int'(ack_ready), 1);
        send_ack(2'b10);
        chk("R8 request kept", int'(req_valid), 1);
        chk("R8 request kind kept", int'(req_kind), 0);
        chk("R9 ready low with flush pending", int'(ack_ready), 0);
        handshake();
        chk("R8 flush answer follows", int'(req_valid), 1);
        chk("R8 flush answer kind", int'(req_kind), 2);
        handshake();
        quiet("R8 idle after flush answer", 4);

        // Flush from idle, then reset mid-transfer: R7 R11
        do_reset();
        send_ack(2'b10);
        chk("R7 flush from idle", int'(req_kind), 2);
        handshake();
        occupancy = 4'd1;
        load(8'd3);
        wait_req("R11 request before reset");
        send_ack(2'b11);
        rst_n = 1'b0;
        step();
        chk("R11 valid low after reset", int'(req_valid), 0);
        chk("R11 error cleared", int'(proto_err), 0);
        chk("R11 ready high", int'(ack_ready), 1);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule